// File: doc/BRIEF.md
# Bus Fault Exception Frame Writer

This block runs the stack side of bus fault entry. When an external abort pulse arrives, it latches the context of the aborted cycle in one clock. That context is the access address, the transfer direction, the function code, the held first instruction word, the program counter, the status register, whether an instruction was in progress, and whether the fault hit the final step of a previous exception entry. The block then pushes a seven-word context record onto the supervisor stack. Each word goes out as one 16-bit write over a request/acknowledge port.

The stack pointer is pre-decremented by two ahead of every word. When the last write is acknowledged, the block raises a one-cycle completion pulse. During that pulse it presents the final stack pointer and the fault vector number, which the caller uses to fetch the new handler. From capture onward it also offers the status register for handler entry: supervisor bit set, trace bit cleared. A further abort that lands while a record is still being pushed does not restart the record. It freezes the block in a halted state that only reset clears.

Top module: `fault_frame_builder`

## Requirements
- R1: After reset, memReq, done and halt are 0 and vecNum is 0.
- R2: An abort pulse seen while idle latches all fault inputs and spIn at that edge. From the next cycle memReq is 1 and memAddr is spIn-2. Changes on the fault inputs after the capture edge have no effect on the record.
- R3: Seven words are written back to back, each at an address 2 below the previous one. While memAck is 0, memReq stays 1 and memAddr and memData hold still. The next word is requested in the cycle after the acknowledge.
- R4: The words go from high address to low in this order: PC[15:0], PC[31:16], status register copy (unmodified), instruction word, fault address[15:0], fault address[31:16], access-info word.
- R5: Access-info word layout: bit 4 is 1 for a read and 0 for a write. Bit 3 is 1 when no instruction was being processed (inInstr = 0). Bits 2:0 carry the function code. All other bits are 0.
- R6: When inVecStep is 1 at capture, the saved program counter is the vector address VEC_BASE + 4*VEC_NUM. Otherwise it is faultPc unchanged.
- R7: In the cycle after the seventh acknowledge, done is 1 for exactly one cycle. In that cycle spOut equals spIn-14 and vecNum equals VEC_NUM; vecNum is 0 otherwise.
- R8: From the cycle after capture, newSr equals the captured status register with bit 13 set and bit 15 cleared, and every other bit unchanged.
- R9: An abort pulse while a record is being written, or in the completion cycle, sets halt from the next cycle. Halt stays 1 until reset, memReq stays 0 and memAck is ignored.
- R10: Once done has fallen, a new abort starts a fresh record from the new spIn and new inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultPulse | input | 1 | One-cycle abort of the current bus cycle |
| faultAddr | input | 32 | Address of the aborted access |
| faultRead | input | 1 | 1 = aborted access was a read |
| faultFc | input | 3 | Function code during the aborted access |
| faultIr | input | 16 | Held first word of the current instruction |
| faultPc | input | 32 | Program counter value to save |
| faultSr | input | 16 | Status register before entry |
| inInstr | input | 1 | 1 = processor was processing an instruction |
| inVecStep | input | 1 | 1 = abort hit the vector read or first handler fetch |
| spIn | input | 32 | Supervisor stack pointer before the push |
| memReq | output | 1 | Word write request |
| memAck | input | 1 | Write accepted |
| memAddr | output | 32 | Write address |
| memData | output | 16 | Write data |
| done | output | 1 | One-cycle record-complete pulse |
| spOut | output | 32 | Stack pointer after the push |
| vecNum | output | 8 | Fault vector number, valid with done |
| newSr | output | 16 | Status register for handler entry |
| halt | output | 1 | Double fault halt |

## Verification
The bench builds the block with VEC_NUM = 3 and VEC_BASE = 0x400, so the substituted program counter is 0x40C. That value cannot be mistaken for zero, for the default vector address or for any supplied program counter, which makes R6 visible in the written words. Acknowledge latency is varied from zero to several cycles, which exercises the hold behaviour of R3. The second-fault cases are struck both in the middle of a word write and during the completion cycle.

// File: rtl/fault_frame_pkg.sv
package fault_frame_pkg;
  localparam int WORD_W       = 16;
  localparam int ADDR_W       = 32;
  localparam int FC_W         = 3;
  localparam int FRAME_WORDS  = 7;
  localparam int IDX_W        = $clog2(FRAME_WORDS);
  localparam int ADDR_HALVES  = ADDR_W / WORD_W;
  localparam int SR_SUPV_BIT  = 13;
  localparam int SR_TRACE_BIT = 15;
  localparam int INFO_RW_BIT  = 4;
  localparam int INFO_NI_BIT  = 3;

  // word positions, high stack address first
  localparam int SEL_PC_LO = 0;
  localparam int SEL_SR    = SEL_PC_LO + ADDR_HALVES;
  localparam int SEL_IR    = SEL_SR + 1;
  localparam int SEL_FA_LO = SEL_IR + 1;
  localparam int SEL_INFO  = SEL_FA_LO + ADDR_HALVES;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_DONE  = 2'd2,
    ST_HALT  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic             capture;
    logic             step;
    logic             last;
    logic [IDX_W-1:0] wordSel;
  } frame_ctrl_t;

  function automatic logic [WORD_W-1:0] pack_info(input logic isRead,
                                                  input logic notInstr,
                                                  input logic [FC_W-1:0] fc);
    logic [WORD_W-1:0] w;
    w = '0;
    w[INFO_RW_BIT] = isRead;
    w[INFO_NI_BIT] = notInstr;
    w[FC_W-1:0]    = fc;
    return w;
  endfunction
endpackage

// File: rtl/fault_frame_ctrl.sv
module fault_frame_ctrl
  import fault_frame_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        faultPulse,
  input  logic        memAck,
  output frame_ctrl_t ctrl,
  output logic        memReq,
  output logic        done,
  output logic        halt
);
  seq_state_e       state, stateNext;
  logic [IDX_W-1:0] wordIdx, wordIdxNext;
  logic             lastWord;

  assign lastWord = (wordIdx == IDX_W'(FRAME_WORDS - 1));

  always_comb begin
    stateNext   = state;
    wordIdxNext = wordIdx;
    case (state)
      ST_IDLE: begin
        if (faultPulse) begin
          stateNext   = ST_WRITE;
          wordIdxNext = '0;
        end
      end
      ST_WRITE: begin
        if (faultPulse) begin
          stateNext = ST_HALT;
        end else if (memAck) begin
          if (lastWord) stateNext = ST_DONE;
          else          wordIdxNext = wordIdx + 1'b1;
        end
      end
      ST_DONE: stateNext = faultPulse ? ST_HALT : ST_IDLE;
      default: stateNext = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
    end else begin
      state   <= stateNext;
      wordIdx <= wordIdxNext;
    end
  end

  always_comb begin
    ctrl.capture = (state == ST_IDLE) && faultPulse;
    ctrl.step    = (state == ST_WRITE) && memAck && !faultPulse;
    ctrl.last    = lastWord;
    ctrl.wordSel = wordIdx;
  end

  assign memReq = (state == ST_WRITE);
  assign done   = (state == ST_DONE);
  assign halt   = (state == ST_HALT);
endmodule

// File: rtl/fault_frame_datapath.sv
module fault_frame_datapath
  import fault_frame_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_ADDR = 32'd8
) (
  input  logic              clk,
  input  logic              rstN,
  input  frame_ctrl_t       ctrl,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              faultRead,
  input  logic [FC_W-1:0]   faultFc,
  input  logic [WORD_W-1:0] faultIr,
  input  logic [ADDR_W-1:0] faultPc,
  input  logic [WORD_W-1:0] faultSr,
  input  logic              inInstr,
  input  logic              inVecStep,
  input  logic [ADDR_W-1:0] spIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memData,
  output logic [ADDR_W-1:0] spOut,
  output logic [WORD_W-1:0] newSr
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(WORD_W / 8);

  logic [ADDR_W-1:0] capPc, capAddr, spReg;
  logic [WORD_W-1:0] capSr, capIr, capInfo, capNewSr;
  logic [WORD_W-1:0] frameWords [FRAME_WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capPc    <= '0;
      capAddr  <= '0;
      capSr    <= '0;
      capIr    <= '0;
      capInfo  <= '0;
      capNewSr <= '0;
      spReg    <= '0;
    end else if (ctrl.capture) begin
      capPc    <= inVecStep ? VEC_ADDR : faultPc;
      capAddr  <= faultAddr;
      capSr    <= faultSr;
      capIr    <= faultIr;
      capInfo  <= pack_info(faultRead, !inInstr, faultFc);
      capNewSr <= (faultSr | (WORD_W'(1) << SR_SUPV_BIT))
                  & ~(WORD_W'(1) << SR_TRACE_BIT);
      spReg    <= spIn - WORD_BYTES;
    end else if (ctrl.step && !ctrl.last) begin
      spReg    <= spReg - WORD_BYTES;
    end
  end

  for (genvar h = 0; h < ADDR_HALVES; h++) begin : g_half
    assign frameWords[SEL_PC_LO + h] = capPc[h*WORD_W +: WORD_W];
    assign frameWords[SEL_FA_LO + h] = capAddr[h*WORD_W +: WORD_W];
  end
  assign frameWords[SEL_SR]   = capSr;
  assign frameWords[SEL_IR]   = capIr;
  assign frameWords[SEL_INFO] = capInfo;

  always_comb begin
    memData = '0;
    for (int i = 0; i < FRAME_WORDS; i++) begin
      if (ctrl.wordSel == IDX_W'(i)) memData = frameWords[i];
    end
  end

  assign memAddr = spReg;
  assign spOut   = spReg;
  assign newSr   = capNewSr;
endmodule

// File: rtl/fault_frame_builder.sv
module fault_frame_builder
  import fault_frame_pkg::*;
#(
  parameter int          VEC_NUM  = 2,
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        faultPulse,
  input  logic [31:0] faultAddr,
  input  logic        faultRead,
  input  logic [2:0]  faultFc,
  input  logic [15:0] faultIr,
  input  logic [31:0] faultPc,
  input  logic [15:0] faultSr,
  input  logic        inInstr,
  input  logic        inVecStep,
  input  logic [31:0] spIn,
  output logic        memReq,
  input  logic        memAck,
  output logic [31:0] memAddr,
  output logic [15:0] memData,
  output logic        done,
  output logic [31:0] spOut,
  output logic [7:0]  vecNum,
  output logic [15:0] newSr,
  output logic        halt
);
  localparam logic [ADDR_W-1:0] VEC_ADDR = VEC_BASE + ADDR_W'(VEC_NUM * 4);

  frame_ctrl_t ctrl;

  fault_frame_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .faultPulse (faultPulse),
    .memAck     (memAck),
    .ctrl       (ctrl),
    .memReq     (memReq),
    .done       (done),
    .halt       (halt)
  );

  fault_frame_datapath #(.VEC_ADDR(VEC_ADDR)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .faultAddr (faultAddr),
    .faultRead (faultRead),
    .faultFc   (faultFc),
    .faultIr   (faultIr),
    .faultPc   (faultPc),
    .faultSr   (faultSr),
    .inInstr   (inInstr),
    .inVecStep (inVecStep),
    .spIn      (spIn),
    .memAddr   (memAddr),
    .memData   (memData),
    .spOut     (spOut),
    .newSr     (newSr)
  );

  assign vecNum = done ? 8'(VEC_NUM) : 8'd0;
endmodule

// File: rtl/fault_frame_checker.sv
module fault_frame_checker #(
  parameter int VEC_NUM = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        faultPulse,
  input logic [31:0] spIn,
  input logic        memReq,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic [15:0] memData,
  input logic        done,
  input logic [7:0]  vecNum,
  input logic        halt
);
  logic idle;
  assign idle = !memReq && !done && !halt;

  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && (done || halt)));

  a_r2_first_write: assert property (@(posedge clk) disable iff (!rstN)
    (idle && faultPulse) |=> (memReq && memAddr == $past(spIn) - 32'd2));

  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !faultPulse) |=>
      (memReq && $stable(memAddr) && $stable(memData)));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !faultPulse) |=>
      (done || (memReq && memAddr == $past(memAddr) - 32'd2)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_vector: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (vecNum == 8'(VEC_NUM)));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    halt |=> (halt && !memReq));

  a_r9_second_fault: assert property (@(posedge clk) disable iff (!rstN)
    ((memReq || done) && faultPulse) |=> halt);
endmodule

bind fault_frame_builder fault_frame_checker #(.VEC_NUM(VEC_NUM)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .faultPulse (faultPulse),
  .spIn       (spIn),
  .memReq     (memReq),
  .memAck     (memAck),
  .memAddr    (memAddr),
  .memData    (memData),
  .done       (done),
  .vecNum     (vecNum),
  .halt       (halt)
);

// File: tb/tb_fault_frame_builder.sv
module tb_fault_frame_builder;
  localparam int          T_VEC_NUM  = 3;
  localparam logic [31:0] T_VEC_BASE = 32'h0000_0400;
  localparam logic [31:0] T_VEC_ADDR = 32'h0000_040C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        faultPulse = 1'b0;
  logic [31:0] faultAddr = '0;
  logic        faultRead = 1'b0;
  logic [2:0]  faultFc = '0;
  logic [15:0] faultIr = '0;
  logic [31:0] faultPc = '0;
  logic [15:0] faultSr = '0;
  logic        inInstr = 1'b0;
  logic        inVecStep = 1'b0;
  logic [31:0] spIn = '0;
  logic        memAck = 1'b0;
  logic        memReq, done, halt;
  logic [31:0] memAddr, spOut;
  logic [15:0] memData, newSr;
  logic [7:0]  vecNum;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fault_frame_builder #(.VEC_NUM(T_VEC_NUM), .VEC_BASE(T_VEC_BASE)) dut (
    .clk(clk), .rstN(rstN), .faultPulse(faultPulse), .faultAddr(faultAddr),
    .faultRead(faultRead), .faultFc(faultFc), .faultIr(faultIr),
    .faultPc(faultPc), .faultSr(faultSr), .inInstr(inInstr),
    .inVecStep(inVecStep), .spIn(spIn), .memReq(memReq), .memAck(memAck),
    .memAddr(memAddr), .memData(memData), .done(done), .spOut(spOut),
    .vecNum(vecNum), .newSr(newSr), .halt(halt)
  );

  task automatic chkEq(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    faultPulse = 1'b0;
    memAck = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulseFault();
    faultPulse = 1'b1;
    @(negedge clk);
    faultPulse = 1'b0;
  endtask

  // Drives one complete record; leaves time at the negedge where done is high.
  task automatic runFrame(input logic [31:0] sp, input logic [31:0] pc,
                          input logic [31:0] addr, input logic [15:0] sr,
                          input logic [15:0] ir, input logic rd,
                          input logic inInst, input logic vecStep,
                          input logic [2:0] fc, input int lat);
    logic [15:0] exp [7];
    logic [31:0] savedPc;
    logic [15:0] expSr;
    savedPc = vecStep ? T_VEC_ADDR : pc;
    exp[0] = savedPc[15:0];
    exp[1] = savedPc[31:16];
    exp[2] = sr;
    exp[3] = ir;
    exp[4] = addr[15:0];
    exp[5] = addr[31:16];
    exp[6] = {11'd0, rd, !inInst, fc};
    expSr  = (sr | 16'h2000) & 16'h7FFF;
    @(negedge clk);
    spIn = sp; faultPc = pc; faultAddr = addr; faultSr = sr; faultIr = ir;
    faultRead = rd; inInstr = inInst; inVecStep = vecStep; faultFc = fc;
    pulseFault();
    // scramble inputs after capture (R2)
    spIn = ~sp; faultPc = ~pc; faultAddr = ~addr; faultSr = ~sr; faultIr = ~ir;
    faultRead = !rd; inInstr = !inInst; inVecStep = !vecStep; faultFc = ~fc;
    chkEq("R8", "newSr", 32'(newSr), 32'(expSr));
    for (int i = 0; i < 7; i++) begin
      chkEq(i == 0 ? "R2" : "R3", "memReq", 32'(memReq), 32'd1);
      chkEq(i == 0 ? "R2" : "R3", "memAddr", memAddr, sp - 32'(2 * (i + 1)));
      chkEq(i == 6 ? "R5" : (i < 2 ? "R6" : "R4"), "memData",
            32'(memData), 32'(exp[i]));
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chkEq("R3", "held req", 32'(memReq), 32'd1);
        chkEq("R3", "held addr", memAddr, sp - 32'(2 * (i + 1)));
        chkEq("R3", "held data", 32'(memData), 32'(exp[i]));
      end
      memAck = 1'b1;
      @(negedge clk);
      memAck = 1'b0;
    end
    chkEq("R7", "done", 32'(done), 32'd1);
    chkEq("R7", "spOut", spOut, sp - 32'd14);
    chkEq("R7", "vecNum", 32'(vecNum), 32'(T_VEC_NUM));
    chkEq("R7", "memReq at done", 32'(memReq), 32'd0);
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    chkEq("R1", "memReq", 32'(memReq), 32'd0);
    chkEq("R1", "done", 32'(done), 32'd0);
    chkEq("R1", "halt", 32'(halt), 32'd0);
    chkEq("R1", "vecNum", 32'(vecNum), 32'd0);
  endtask

  task automatic testReadInInstr();
    runFrame(32'h0000_8000, 32'h0001_2346, 32'hABCD_1234, 16'h2704,
             16'h4E71, 1'b1, 1'b1, 1'b0, 3'd6, 0);
    @(negedge clk);
    chkEq("R7", "done falls", 32'(done), 32'd0);
    chkEq("R7", "vecNum idle", 32'(vecNum), 32'd0);
  endtask

  task automatic testVecStepWrite();
    runFrame(32'h0010_0100, 32'hDEAD_BEE0, 32'h00FF_0012, 16'h8015,
             16'h3A5C, 1'b0, 1'b0, 1'b1, 3'd5, 3);
    @(negedge clk);
  endtask

  task automatic testBackToBack();
    // R10: fresh record right after the previous one
    runFrame(32'h0000_2000, 32'h0000_0100, 32'h0000_0200, 16'h0000,
             16'hFFFF, 1'b1, 1'b0, 1'b0, 3'd1, 1);
    @(negedge clk);
    chkEq("R10", "idle after done", 32'(memReq), 32'd0);
    runFrame(32'h0000_3000, 32'h8765_4320, 32'h1357_9BDF, 16'hFFFF,
             16'h0001, 1'b0, 1'b1, 1'b0, 3'd2, 2);
    @(negedge clk);
  endtask

  task automatic testHaltMidFrame();
    @(negedge clk);
    spIn = 32'h0000_5000;
    pulseFault();
    for (int i = 0; i < 2; i++) begin
      memAck = 1'b1;
      @(negedge clk);
      memAck = 1'b0;
    end
    chkEq("R9", "req before fault", 32'(memReq), 32'd1);
    pulseFault();
    chkEq("R9", "halt set", 32'(halt), 32'd1);
    chkEq("R9", "req dropped", 32'(memReq), 32'd0);
    memAck = 1'b1;
    repeat (4) @(negedge clk);
    memAck = 1'b0;
    pulseFault();
    chkEq("R9", "halt sticky", 32'(halt), 32'd1);
    chkEq("R9", "no req in halt", 32'(memReq), 32'd0);
    chkEq("R9", "no done in halt", 32'(done), 32'd0);
    doReset();
    @(negedge clk);
    chkEq("R9", "reset clears halt", 32'(halt), 32'd0);
  endtask

  task automatic testHaltAtDone();
    runFrame(32'h0000_6000, 32'h0000_1000, 32'h0000_2000, 16'h0700,
             16'h1234, 1'b1, 1'b1, 1'b0, 3'd6, 0);
    pulseFault();
    chkEq("R9", "halt from done cycle", 32'(halt), 32'd1);
    chkEq("R9", "no req after done fault", 32'(memReq), 32'd0);
    doReset();
  endtask

  initial begin
    testReset();
    testReadInInstr();
    testVecStepWrite();
    testBackToBack();
    testHaltMidFrame();
    testHaltAtDone();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule